// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

A passive observer for a synchronous DRAM command bus. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable pins together with the bank field and the auto-precharge/all-banks address bit. It keeps a small state machine and down-counter for every bank, and decides whether the sampled command is legal for the bank it addresses. For device-wide commands it checks every bank. The monitor drives nothing on the memory bus. It raises a one-cycle violation pulse with a two-bit class code that a testbench or an on-chip debug path can consume.

An illegal command is treated as if it never happened: no bank state changes because of it, and the per-bank timers keep running. Timing windows are counted in clock cycles from parameters: activate-to-access delay, precharge time, refresh cycle time, mode-set time, activate-to-activate spacing, write recovery and burst length. Each timing parameter must be at least 2. The bank count must be a power of two.

The command encoding on {row strobe, column strobe, write enable}, all active low with chip select low, is: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no operation. Chip select high is a deselect.

Top module: `sdcmd_monitor`

## Requirements
- R1: Refresh (001) and mode set (000) are legal only when every bank is idle. Otherwise they flag code 1 (not idle).
- R2: On an idle bank, activate is legal and precharge is a legal no-op. Read, write and burst stop flag code 2 (busy / wrong state).
- R3: An activate to a bank that holds an open row or a burst flags code 1. An activate to a bank in a timed transient state (opening, closing, refreshing, mode set) flags code 2.
- R4: After an accepted activate, the bank rejects read, write, precharge and burst stop with code 2 for T_RCD-1 cycles. A read exactly T_RCD cycles after the activate is legal.
- R5: During a read or write burst without auto-precharge, read, write, precharge and burst stop to that bank are legal and end the burst. Without a new command, the bank goes back to row-open BURST_LEN cycles after the access.
- R6: A read or write issued with the auto-precharge bit high starts a burst in which read, write, precharge and burst stop flag code 2 and activate flags code 1. After a read burst the bank stays closing for T_RP cycles, then goes idle.
- R7: A closing bank accepts only no operation or deselect, with code 2 for anything else. It is idle T_RP cycles after the accepted precharge, when activate becomes legal.
- R8: After an accepted refresh every bank is busy for T_RFC-1 cycles, and after an accepted mode set for T_MRD-1 cycles. Each bank is idle after that.
- R9: An activate to an idle bank within T_RRD-1 cycles after the last accepted activate flags code 3 (spacing).
- R10: When a write burst ends, the bank spends T_WR cycles in write recovery. A burst stop on a write enters recovery for T_WR-1 cycles. During recovery, precharge flags code 2 while read, write and burst stop are legal.
- R11: A precharge with the all-banks bit high is judged against every bank and is legal only if every bank allows a precharge. If all banks are idle it is a no-op.
- R12: The violation pulse is high for exactly the one cycle after the offending edge, with code 1, 2 or 3. Otherwise the pulse is low and the code is 0. An illegal command changes no bank state.
- R13: No operation and deselect never flag. A command to one bank is judged only against that bank's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_n | input | 1 | Chip select, active low |
| bus_ras_n | input | 1 | Row strobe, active low |
| bus_cas_n | input | 1 | Column strobe, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_bank | input | BANK_W | Bank field of the command |
| bus_ap | input | 1 | Auto-precharge on read/write, all-banks on precharge |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 2 | 0 none, 1 not idle, 2 busy/wrong state, 3 activate spacing |

## Verification
Each verdict is registered once, so the pulse and code for a command sampled on a rising edge appear right after that same edge and hold for one cycle. The bench drives each command on a falling edge and samples 1 ns after the next rising edge, so every check reads the verdict of exactly one command. Timed windows are checked at both of their edges, for example an access one cycle before and exactly at T_RCD, or an activate at T_RP versus T_RP+1 after an auto-precharge burst. These cycle numbers are counted from the edge that accepted the command, with no-operation steps in between.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_MRS, CMD_REF, CMD_PRE,
    CMD_ACT, CMD_WR, CMD_RD, CMD_BST
  } cmd_e;

  typedef enum logic [3:0] {
    BK_IDLE, BK_OPENING, BK_OPEN, BK_RD, BK_WR, BK_RD_AP,
    BK_WR_AP, BK_WREC, BK_CLOSING, BK_REFRESH, BK_MODESET
  } bank_st_e;

  typedef enum logic [1:0] {
    VC_NONE     = 2'd0,
    VC_NOT_IDLE = 2'd1,
    VC_BUSY     = 2'd2,
    VC_SPACING  = 2'd3
  } viol_e;

  // states that reject everything until a timer expires
  function automatic logic is_transient(bank_st_e s);
    return (s == BK_OPENING) || (s == BK_CLOSING) ||
           (s == BK_REFRESH) || (s == BK_MODESET);
  endfunction

  // states with an open row that accept column commands
  function automatic logic row_ready(bank_st_e s);
    return (s == BK_OPEN) || (s == BK_RD) || (s == BK_WR) || (s == BK_WREC);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic sel_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (sel_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b010:  cmd = CMD_PRE;
        3'b011:  cmd = CMD_ACT;
        3'b100:  cmd = CMD_WR;
        3'b101:  cmd = CMD_RD;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_spacing.sv
module sdcmd_spacing #(
  parameter int T_RRD = 2,
  localparam int SW = $clog2(T_RRD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_ok,
  output logic busy_o
);
  localparam logic [SW-1:0] LOAD = SW'(T_RRD - 1);
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (act_ok)      cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cmd_e     cmd,
  input  logic     hit,
  input  logic     all_pre,
  input  logic     auto_pre,
  input  logic     accept,
  output bank_st_e state_o,
  output viol_e    verdict_o
);
  // loads on a command edge cover T-1 cycles; chained loads cover T cycles
  localparam logic [CNT_W-1:0] L_RCD  = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_RP   = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] L_RFC  = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] L_MRD  = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] L_BL   = CNT_W'(BURST_LEN - 1);
  localparam logic [CNT_W-1:0] L_WRAP = CNT_W'(BURST_LEN - 1 + T_WR);
  localparam logic [CNT_W-1:0] L_BSTW = CNT_W'(T_WR - 1);
  localparam logic [CNT_W-1:0] C_WR   = CNT_W'(T_WR);
  localparam logic [CNT_W-1:0] C_RP   = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  bank_st_e        st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  // legality of the sampled command as seen by this bank
  always_comb begin
    verdict_o = VC_NONE;
    case (cmd)
      CMD_REF, CMD_MRS:
        if (st != BK_IDLE) verdict_o = VC_NOT_IDLE;
      CMD_ACT:
        if (hit && st != BK_IDLE)
          verdict_o = is_transient(st) ? VC_BUSY : VC_NOT_IDLE;
      CMD_RD, CMD_WR, CMD_BST:
        if (hit && !row_ready(st)) verdict_o = VC_BUSY;
      CMD_PRE:
        if ((hit || all_pre) &&
            !(st == BK_IDLE || st == BK_OPEN || st == BK_RD || st == BK_WR))
          verdict_o = VC_BUSY;
      default: ;
    endcase
  end

  // timer expiry first, then an accepted command overrides it
  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (cnt == ONE) begin
      cnt_n = '0;
      case (st)
        BK_OPENING, BK_RD, BK_WREC:      st_n = BK_OPEN;
        BK_WR:                           begin st_n = BK_WREC;    cnt_n = C_WR; end
        BK_RD_AP, BK_WR_AP:              begin st_n = BK_CLOSING; cnt_n = C_RP; end
        BK_CLOSING, BK_REFRESH, BK_MODESET: st_n = BK_IDLE;
        default: ;
      endcase
    end else if (cnt != '0) begin
      cnt_n = cnt - 1'b1;
    end

    if (accept) begin
      case (cmd)
        CMD_ACT: if (hit) begin st_n = BK_OPENING; cnt_n = L_RCD; end
        CMD_RD:  if (hit) begin st_n = auto_pre ? BK_RD_AP : BK_RD; cnt_n = L_BL; end
        CMD_WR:  if (hit) begin
                   st_n  = auto_pre ? BK_WR_AP : BK_WR;
                   cnt_n = auto_pre ? L_WRAP : L_BL;
                 end
        CMD_PRE: if ((hit || all_pre) && st != BK_IDLE) begin
                   st_n = BK_CLOSING; cnt_n = L_RP;
                 end
        CMD_BST: if (hit && st == BK_RD) begin
                   st_n = BK_OPEN; cnt_n = '0;
                 end else if (hit && st == BK_WR) begin
                   st_n = BK_WREC; cnt_n = L_BSTW;
                 end
        CMD_REF: begin st_n = BK_REFRESH; cnt_n = L_RFC; end
        CMD_MRS: begin st_n = BK_MODESET; cnt_n = L_MRD; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= BK_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign state_o = st;
endmodule

// File: rtl/sdcmd_monitor.sv
module sdcmd_monitor
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8,
  parameter int T_MRD     = 2,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_ras_n,
  input  logic              bus_cas_n,
  input  logic              bus_we_n,
  input  logic [BANK_W-1:0] bus_bank,
  input  logic              bus_ap,
  output logic              viol_o,
  output logic [1:0]        viol_code_o
);
  localparam int MAX_T = max2(max2(max2(T_RCD, T_RP), max2(T_RFC, T_MRD)),
                              BURST_LEN + T_WR);
  localparam int CNT_W = $clog2(MAX_T + 1);

  cmd_e                      cmd_now;
  bank_st_e [NUM_BANKS-1:0]  bank_st;
  viol_e                     verdict [NUM_BANKS];
  viol_e                     code_c;
  logic                      all_pre, accept, rrd_busy;

  sdcmd_decode u_dec (
    .sel_n (bus_sel_n),
    .ras_n (bus_ras_n),
    .cas_n (bus_cas_n),
    .we_n  (bus_we_n),
    .cmd   (cmd_now)
  );

  assign all_pre = (cmd_now == CMD_PRE) && bus_ap;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdcmd_bank #(
      .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
      .T_MRD(T_MRD), .T_WR(T_WR), .BURST_LEN(BURST_LEN)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd_now),
      .hit       (bus_bank == BANK_W'(g)),
      .all_pre   (all_pre),
      .auto_pre  (bus_ap),
      .accept    (accept),
      .state_o   (bank_st[g]),
      .verdict_o (verdict[g])
    );
  end

  sdcmd_spacing #(.T_RRD(T_RRD)) u_spacing (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_ok (accept && (cmd_now == CMD_ACT)),
    .busy_o (rrd_busy)
  );

  // lowest-numbered objecting bank decides the class; spacing only if none
  always_comb begin
    code_c = VC_NONE;
    for (int i = NUM_BANKS - 1; i >= 0; i--)
      if (verdict[i] != VC_NONE) code_c = verdict[i];
    if (cmd_now == CMD_ACT && code_c == VC_NONE && rrd_busy)
      code_c = VC_SPACING;
  end

  assign accept = (code_c == VC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_o      <= 1'b0;
      viol_code_o <= 2'd0;
    end else begin
      viol_o      <= (code_c != VC_NONE);
      viol_code_o <= code_c;
    end
  end
endmodule

// File: rtl/sdcmd_monitor_chk.sv
module sdcmd_monitor_chk
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input cmd_e                     cmd,
  input logic [BANK_W-1:0]        bank,
  input bank_st_e [NUM_BANKS-1:0] bank_st,
  input logic                     viol,
  input logic [1:0]               code
);
  logic any_busy;
  always_comb begin
    any_busy = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (bank_st[i] != BK_IDLE) any_busy = 1'b1;
  end

  assert_all_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_REF || cmd == CMD_MRS) && any_busy) |=> (viol && code == 2'd1));

  assert_idle_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_RD || cmd == CMD_WR || cmd == CMD_BST) && bank_st[bank] == BK_IDLE)
      |=> (viol && code == 2'd2));

  assert_closing_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_ACT || cmd == CMD_RD || cmd == CMD_WR || cmd == CMD_BST) &&
     bank_st[bank] == BK_CLOSING) |=> (viol && code == 2'd2));

  assert_pulse_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (code != 2'd0));

  assert_quiet_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> (code == 2'd0));

  assert_nop_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP || cmd == CMD_DESEL) |=> !viol);
endmodule

bind sdcmd_monitor sdcmd_monitor_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd     (cmd_now),
  .bank    (bus_bank),
  .bank_st (bank_st),
  .viol    (viol_o),
  .code    (viol_code_o)
);

// File: tb/sdcmd_monitor_test.sv
`timescale 1ns/1ps
module sdcmd_monitor_test;
  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                         C_ACT = 3'b011, C_WR  = 3'b100, C_RD  = 3'b101,
                         C_BST = 3'b110, C_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ap = 1'b0;
  logic [1:0] bank = 2'd0;
  logic viol;
  logic [1:0] code;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdcmd_monitor uut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(sel_n), .bus_ras_n(ras_n),
    .bus_cas_n(cas_n), .bus_we_n(we_n), .bus_bank(bank), .bus_ap(ap),
    .viol_o(viol), .viol_code_o(code)
  );

  task automatic check(input logic [1:0] exp, input string tag);
    n_chk++;
    if (viol !== (exp != 2'd0) || code !== exp) begin
      n_fail++;
      $display("FAIL %s: viol=%0b code=%0d, expected viol=%0b code=%0d",
               tag, viol, code, exp != 2'd0, exp);
    end
  endtask

  // one command per cycle: drive on falling edge, sample after the rising edge
  task automatic step(input logic [2:0] rcw, input int bk, input logic apb,
                      input logic seln, input logic [1:0] exp, input string tag);
    @(negedge clk);
    sel_n = seln; {ras_n, cas_n, we_n} = rcw; bank = bk[1:0]; ap = apb;
    @(posedge clk);
    #1;
    check(exp, tag);
    sel_n = 1'b0; {ras_n, cas_n, we_n} = C_NOP; ap = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] rcw, input int bk, input logic apb,
                     input logic [1:0] exp, input string tag);
    step(rcw, bk, apb, 1'b0, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cmd(C_NOP, 0, 1'b0, 2'd0, "R13 nop");
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    check(2'd0, "R12 reset state");
  endtask

  task automatic t_idle_bank;
    cmd(C_RD,  0, 1'b0, 2'd2, "R2 read on idle");
    cmd(C_WR,  0, 1'b0, 2'd2, "R2 write on idle");
    cmd(C_BST, 0, 1'b0, 2'd2, "R2 burst stop on idle");
    cmd(C_PRE, 0, 1'b0, 2'd0, "R2 precharge on idle");
    cmd(C_PRE, 2, 1'b1, 2'd0, "R11 precharge-all when idle");
    cmd(C_NOP, 0, 1'b0, 2'd0, "R13 nop");
    step(C_RD, 0, 1'b0, 1'b1, 2'd0, "R13 deselect");
  endtask

  task automatic t_open_read;
    cmd(C_ACT, 0, 1'b0, 2'd0, "R2 activate idle");       // k
    cmd(C_RD,  0, 1'b0, 2'd2, "R4 read while opening");   // k+1
    idle(1);                                              // k+2
    cmd(C_RD,  0, 1'b0, 2'd0, "R4 read at T_RCD");        // k+3
    cmd(C_REF, 0, 1'b0, 2'd1, "R1 refresh with open bank");
    cmd(C_ACT, 0, 1'b0, 2'd1, "R3 activate during read");
    cmd(C_RD,  0, 1'b0, 2'd0, "R5 read ends read burst");
    cmd(C_PRE, 0, 1'b0, 2'd0, "R5 precharge ends read burst"); // p
    cmd(C_RD,  0, 1'b0, 2'd2, "R7 read while closing");
    cmd(C_ACT, 0, 1'b0, 2'd2, "R3 activate while closing");
    cmd(C_ACT, 0, 1'b0, 2'd0, "R7 activate at T_RP, R12 no state change");
    idle(2);
    cmd(C_PRE, 0, 1'b0, 2'd0, "R5 precharge open row");
    idle(3);
  endtask

  task automatic t_spacing_refresh;
    cmd(C_ACT, 1, 1'b0, 2'd0, "R9 first activate");           // s
    cmd(C_ACT, 2, 1'b0, 2'd3, "R9 activate too soon");
    cmd(C_ACT, 2, 1'b0, 2'd0, "R9 activate at T_RRD");
    cmd(C_ACT, 3, 1'b0, 2'd3, "R9 spacing restarts");
    cmd(C_PRE, 0, 1'b1, 2'd2, "R11 precharge-all with opening bank");
    cmd(C_RD,  1, 1'b0, 2'd0, "R13 read bank1 independent");
    cmd(C_PRE, 3, 1'b1, 2'd0, "R11 precharge-all legal");     // s+6
    cmd(C_REF, 0, 1'b0, 2'd1, "R1 refresh while closing");
    cmd(C_REF, 0, 1'b0, 2'd1, "R1 refresh at last closing cycle");
    cmd(C_REF, 0, 1'b0, 2'd0, "R1 refresh all idle");         // s+9
    cmd(C_ACT, 0, 1'b0, 2'd2, "R8 activate during refresh");
    cmd(C_REF, 0, 1'b0, 2'd1, "R1 refresh during refresh");
    idle(4);
    cmd(C_ACT, 0, 1'b0, 2'd2, "R8 activate at T_RFC-1");
    cmd(C_ACT, 0, 1'b0, 2'd0, "R8 activate at T_RFC");        // s+17
    idle(1);
    cmd(C_PRE, 0, 1'b0, 2'd2, "R4 precharge at T_RCD-1");
    cmd(C_PRE, 0, 1'b0, 2'd0, "R4 precharge at T_RCD");       // s+20
    idle(1);
    cmd(C_MRS, 0, 1'b0, 2'd1, "R1 mode set while closing");
    cmd(C_MRS, 0, 1'b0, 2'd0, "R1 mode set all idle");        // s+23
    cmd(C_ACT, 0, 1'b0, 2'd2, "R8 activate during mode set");
    cmd(C_ACT, 0, 1'b0, 2'd0, "R8 activate at T_MRD");
    idle(2);
    cmd(C_PRE, 0, 1'b0, 2'd0, "R5 close bank0");
    idle(3);
  endtask

  task automatic t_auto_precharge;
    cmd(C_ACT, 3, 1'b0, 2'd0, "R6 open bank3");
    idle(2);
    cmd(C_RD,  3, 1'b1, 2'd0, "R6 read with auto-precharge");  // a
    cmd(C_RD,  3, 1'b0, 2'd2, "R6 read in auto burst");
    cmd(C_ACT, 3, 1'b0, 2'd1, "R6 activate in auto burst");
    cmd(C_PRE, 3, 1'b0, 2'd2, "R6 precharge in auto burst");
    cmd(C_BST, 3, 1'b0, 2'd2, "R7 burst stop while closing");
    idle(1);
    cmd(C_ACT, 3, 1'b0, 2'd2, "R6 activate before auto close ends");
    cmd(C_ACT, 3, 1'b0, 2'd0, "R6 activate after auto close");
    idle(2);
  endtask

  task automatic t_write_recovery;
    cmd(C_WR,  3, 1'b0, 2'd0, "R10 write");                   // w
    idle(3);
    cmd(C_PRE, 3, 1'b0, 2'd2, "R10 precharge in recovery");
    cmd(C_WR,  3, 1'b0, 2'd0, "R10 write in recovery");       // w+5
    cmd(C_BST, 3, 1'b0, 2'd0, "R10 burst stop on write");
    cmd(C_PRE, 3, 1'b0, 2'd2, "R10 precharge after write stop");
    cmd(C_PRE, 3, 1'b0, 2'd0, "R10 precharge after recovery");
    idle(3);
    cmd(C_ACT, 2, 1'b0, 2'd0, "R6 open bank2");
    idle(2);
    cmd(C_WR,  2, 1'b1, 2'd0, "R6 write with auto-precharge");
    cmd(C_WR,  2, 1'b0, 2'd2, "R6 write in auto write burst");
    cmd(C_MRS, 0, 1'b0, 2'd1, "R1 mode set during auto write");
    idle(10);
    cmd(C_ACT, 2, 1'b0, 2'd0, "R6 bank2 idle after auto write");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    sel_n = 1'b0;
    t_reset();
    t_idle_bank();
    t_open_read();
    t_spacing_refresh();
    t_auto_precharge();
    t_write_recovery();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule